// File: doc/BRIEF.md
# Indirect Message Bus Access Bridge

This block gives software a path to an internal message bus that sits outside the normal configuration space. Three 32-bit registers form an index/data window: a control register that names the operation and target, a data register that holds write data or collects read results, and an extension register that supplies the high part of the target offset. Storing into the data or extension register has no side effect. Storing into the control register fires one bus transaction built from the fields just written and the values already held.

Reads on the bus are non-posted. The register write port holds off all further writes, through a ready signal, until the bus target returns the read data and that data has been loaded into the data register. Write transactions and any other opcode finish as soon as the bus accepts the request. Software polls nothing: the stalled write is the completion.

Top module: `msgbus_bridge`

## Requirements
- R1: After reset the control (offset 0xD0), data (0xD4) and extension (0xD8) registers read back zero, `reg_wr_ready` is high and `mb_req_valid` is low.
- R2: A write accepted at 0xD4 or 0xD8 stores the value, which then reads back at that offset, and raises no bus request.
- R3: A write accepted at 0xD0 raises `mb_req_valid` in the following cycle for exactly one request, with opcode = bits 31:24, port = bits 23:16, byte enables = bits 7:4 of the written value, and offset = {extension bits 31:8, written bits 15:8}.
- R4: For opcode 0x11 (write), `mb_req_wdata` equals the data register contents; the request completes when `mb_req_ready` is seen with `mb_req_valid`.
- R5: For opcode 0x10 (read), after acceptance the bridge keeps `reg_wr_ready` low until `mb_rsp_valid`; the `mb_rsp_data` value is then stored in the data register and `reg_wr_ready` returns high in the next cycle.
- R6: Any opcode other than 0x10 and 0x11 is sent with `mb_req_wdata` zero, completes on acceptance, and leaves the data register unchanged.
- R7: `reg_wr_ready` is low from the cycle after a control write until the transaction completes; a write presented while it is low is ignored and changes no register.
- R8: While `mb_req_valid` is high and `mb_req_ready` is low, the request stays valid and all request fields hold their values.
- R9: `mb_rsp_valid` is ignored unless a read response is awaited; the data register stays unchanged.
- R10: Writes to any offset other than 0xD0, 0xD4 and 0xD8 are ignored, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write value |
| reg_wr_ready | output | 1 | High when a write can be taken this cycle |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read value (combinational) |
| mb_req_valid | output | 1 | Bus request valid |
| mb_req_ready | input | 1 | Bus request accepted |
| mb_req_op | output | 8 | Bus opcode |
| mb_req_port | output | 8 | Bus target port |
| mb_req_offset | output | 32 | Bus target offset |
| mb_req_be | output | 4 | Bus byte enables |
| mb_req_wdata | output | 32 | Bus write data |
| mb_rsp_valid | input | 1 | Read response valid |
| mb_rsp_data | input | 32 | Read response data |

## Verification
A wrong sequencer state appears at the ports within one cycle: `reg_wr_ready` or `mb_req_valid` takes the wrong level on the very next clock after a control write, an acceptance or a response. A wrong stored register value shows on `reg_rd_data` in the same cycle it is read, and on `mb_req_offset` or `mb_req_wdata` in the first request cycle that uses it. The bench therefore compares every output against its model each cycle, so a fault surfaces at the first cycle it touches, including under stalled acceptance, delayed responses and stray responses.

// File: rtl/msgbus_bridge.sv
module msgbus_bridge #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter logic [7:0]  CTRL_OFS = 8'hD0,
  parameter logic [7:0]  DATA_OFS = 8'hD4,
  parameter logic [7:0]  EXT_OFS  = 8'hD8,
  parameter logic [7:0]  OP_RD    = 8'h10,
  parameter logic [7:0]  OP_WR    = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [AW-1:0] reg_wr_addr,
  input  logic [DW-1:0] reg_wr_data,
  output logic          reg_wr_ready,
  input  logic [AW-1:0] reg_rd_addr,
  output logic [DW-1:0] reg_rd_data,
  output logic          mb_req_valid,
  input  logic          mb_req_ready,
  output logic [7:0]    mb_req_op,
  output logic [7:0]    mb_req_port,
  output logic [DW-1:0] mb_req_offset,
  output logic [3:0]    mb_req_be,
  output logic [DW-1:0] mb_req_wdata,
  input  logic          mb_rsp_valid,
  input  logic [DW-1:0] mb_rsp_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_t;

  seq_t          seq_q;
  logic [DW-1:0] ctrl_q, data_q, ext_q;
  logic          wr_go, is_rd, is_wr;

  assign reg_wr_ready = (seq_q == S_IDLE);
  assign wr_go        = reg_wr_en && reg_wr_ready;
  assign mb_req_valid = (seq_q == S_REQ);

  assign mb_req_op     = ctrl_q[31:24];
  assign mb_req_port   = ctrl_q[23:16];
  assign mb_req_be     = ctrl_q[7:4];
  assign mb_req_offset = {ext_q[31:8], ctrl_q[15:8]};
  assign is_rd         = (mb_req_op == OP_RD);
  assign is_wr         = (mb_req_op == OP_WR);
  assign mb_req_wdata  = is_wr ? data_q : '0;

  always_comb begin
    case (reg_rd_addr)
      CTRL_OFS: reg_rd_data = ctrl_q;
      DATA_OFS: reg_rd_data = data_q;
      EXT_OFS:  reg_rd_data = ext_q;
      default:  reg_rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q  <= S_IDLE;
      ctrl_q <= '0;
      data_q <= '0;
      ext_q  <= '0;
    end else begin
      case (seq_q)
        S_IDLE: if (wr_go) begin
          case (reg_wr_addr)
            CTRL_OFS: begin ctrl_q <= reg_wr_data; seq_q <= S_REQ; end
            DATA_OFS: data_q <= reg_wr_data;
            EXT_OFS:  ext_q  <= reg_wr_data;
            default:  ;
          endcase
        end
        S_REQ: if (mb_req_ready) seq_q <= is_rd ? S_WAIT : S_IDLE;
        S_WAIT: if (mb_rsp_valid) begin
          data_q <= mb_rsp_data;
          seq_q  <= S_IDLE;
        end
        default: seq_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msgbus_bridge_chk.sv
module msgbus_bridge_chk #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter logic [7:0]  CTRL_OFS = 8'hD0,
  parameter logic [7:0]  OP_RD    = 8'h10,
  parameter logic [7:0]  OP_WR    = 8'h11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_wr_addr,
  input logic          reg_wr_ready,
  input logic          mb_req_valid,
  input logic          mb_req_ready,
  input logic [7:0]    mb_req_op,
  input logic [7:0]    mb_req_port,
  input logic [DW-1:0] mb_req_offset,
  input logic [3:0]    mb_req_be,
  input logic [DW-1:0] mb_req_wdata,
  input logic          mb_rsp_valid,
  input logic [DW-1:0] mb_rsp_data,
  input logic [DW-1:0] data_q
);

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_wr_ready && reg_wr_addr == CTRL_OFS |=> mb_req_valid);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid |-> !reg_wr_ready);

  // R8
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && !mb_req_ready |=> mb_req_valid && $stable(mb_req_op) &&
      $stable(mb_req_port) && $stable(mb_req_offset) && $stable(mb_req_be) &&
      $stable(mb_req_wdata));

  // R5
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && mb_req_ready && mb_req_op == OP_RD |=> !reg_wr_ready && !mb_req_valid);

  // R5
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_ready && !mb_req_valid && mb_rsp_valid |=> reg_wr_ready && data_q == $past(mb_rsp_data));

  // R6
  posted_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && mb_req_ready && mb_req_op != OP_RD |=> reg_wr_ready);

  // R4
  wdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && mb_req_op == OP_WR |-> mb_req_wdata == data_q);

  // R6
  nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req_valid && mb_req_op != OP_WR |-> mb_req_wdata == '0);

  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_ready && mb_rsp_valid && !(reg_wr_en && reg_wr_addr != CTRL_OFS) |=> $stable(data_q));

endmodule

bind msgbus_bridge msgbus_bridge_chk #(
  .AW(AW), .DW(DW), .CTRL_OFS(CTRL_OFS), .OP_RD(OP_RD), .OP_WR(OP_WR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .reg_wr_ready(reg_wr_ready), .mb_req_valid(mb_req_valid), .mb_req_ready(mb_req_ready),
  .mb_req_op(mb_req_op), .mb_req_port(mb_req_port), .mb_req_offset(mb_req_offset),
  .mb_req_be(mb_req_be), .mb_req_wdata(mb_req_wdata), .mb_rsp_valid(mb_rsp_valid),
  .mb_rsp_data(mb_rsp_data), .data_q(data_q)
);

// File: tb/sim_msgbus_bridge.sv
module sim_msgbus_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0;
  logic [7:0]  reg_wr_addr = 0;
  logic [31:0] reg_wr_data = 0;
  logic        reg_wr_ready;
  logic [7:0]  reg_rd_addr = 8'hD0;
  logic [31:0] reg_rd_data;
  logic        mb_req_valid;
  logic        mb_req_ready = 0;
  logic [7:0]  mb_req_op, mb_req_port;
  logic [31:0] mb_req_offset, mb_req_wdata;
  logic [3:0]  mb_req_be;
  logic        mb_rsp_valid = 0;
  logic [31:0] mb_rsp_data = 0;

  msgbus_bridge u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // reference model: phase 0 idle, 1 requesting, 2 awaiting read data
  int          m_ph;
  logic [31:0] m_c, m_d, m_x;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_c = 0; m_d = 0; m_x = 0;
    end else if (m_ph == 0) begin
      if (reg_wr_en) begin
        if (reg_wr_addr == 8'hD0) begin m_c = reg_wr_data; m_ph = 1; end
        else if (reg_wr_addr == 8'hD4) m_d = reg_wr_data;
        else if (reg_wr_addr == 8'hD8) m_x = reg_wr_data;
      end
    end else if (m_ph == 1) begin
      if (mb_req_ready) m_ph = (m_c[31:24] == 8'h10) ? 2 : 0;
    end else if (mb_rsp_valid) begin
      m_d = mb_rsp_data; m_ph = 0;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'hD0: return m_c;
      8'hD4: return m_d;
      8'hD8: return m_x;
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cmp({31'b0, reg_wr_ready}, {31'b0, m_ph == 0}, "R7 reg_wr_ready");
      cmp({31'b0, mb_req_valid}, {31'b0, m_ph == 1}, "R3/R8 mb_req_valid");
      cmp(reg_rd_data, m_read(reg_rd_addr), "R2/R5/R9/R10 reg_rd_data");
      if (m_ph == 1) begin
        cmp({24'b0, mb_req_op}, {24'b0, m_c[31:24]}, "R3 mb_req_op");
        cmp({24'b0, mb_req_port}, {24'b0, m_c[23:16]}, "R3 mb_req_port");
        cmp({28'b0, mb_req_be}, {28'b0, m_c[7:4]}, "R3 mb_req_be");
        cmp(mb_req_offset, {m_x[31:8], m_c[15:8]}, "R3 mb_req_offset");
        cmp(mb_req_wdata, (m_c[31:24] == 8'h11) ? m_d : 32'h0, "R4/R6 mb_req_wdata");
      end
    end
  end

  // bus target: stall count, response delay, stray response injection
  int          stall = 0, rsp_dly = 0, rsp_wait = 0;
  bit          pend = 0, rd_flag = 0, stray = 0;
  logic [31:0] rsp_val = 0;

  always @(negedge clk) begin
    #1;
    if (mb_req_ready && rd_flag) begin pend = 1; rsp_wait = rsp_dly; end
    mb_rsp_valid = 0;
    if (stray) begin mb_rsp_valid = 1; mb_rsp_data = 32'hBAD0_BAD0; stray = 0; end
    else if (pend) begin
      if (rsp_wait == 0) begin mb_rsp_valid = 1; mb_rsp_data = rsp_val; pend = 0; end
      else rsp_wait--;
    end
    mb_req_ready = 0; rd_flag = 0;
    if (mb_req_valid) begin
      if (stall > 0) stall--;
      else begin mb_req_ready = 1; rd_flag = (mb_req_op == 8'h10); end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    forever begin
      @(posedge clk);
      if (reg_wr_ready) break;
    end
    @(negedge clk); #2;
    reg_wr_en = 0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); #2;
    reg_wr_en = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!reg_wr_ready) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string what);
    @(negedge clk); #2;
    reg_rd_addr = a;
    #1;
    cmp(reg_rd_data, exp, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd_chk(8'hD0, 0, "R1 ctrl reset");
    rd_chk(8'hD4, 0, "R1 data reset");
    rd_chk(8'hD8, 0, "R1 ext reset");
    cmp({31'b0, reg_wr_ready}, 1, "R1 ready reset");
    cmp({31'b0, mb_req_valid}, 0, "R1 valid reset");
    // R2 plain stores
    wr(8'hD4, 32'hCAFE_F00D);
    wr(8'hD8, 32'h1234_5600);
    rd_chk(8'hD4, 32'hCAFE_F00D, "R2 data readback");
    rd_chk(8'hD8, 32'h1234_5600, "R2 ext readback");
    // R10 unmapped
    wr(8'hDC, 32'hFFFF_FFFF);
    rd_chk(8'hDC, 0, "R10 unmapped read");
    rd_chk(8'hD4, 32'hCAFE_F00D, "R10 data untouched");
    // R4 write op, immediate accept
    wr(8'hD0, 32'h1105_3AF0);
    wait_idle();
    // R8 write op with stalls
    stall = 3;
    wr(8'hD0, 32'h11AA_77C0);
    wait_idle();
    // R5 read op with delayed response, busy writes ignored (R7)
    rsp_val = 32'h5A5A_0001; rsp_dly = 4; stall = 1;
    wr(8'hD0, 32'h1003_0410);
    poke(8'hD4, 32'h0BAD_0BAD);
    poke(8'hD0, 32'h11FF_FFFF);
    wait_idle();
    rd_chk(8'hD4, 32'h5A5A_0001, "R5 read data loaded");
    // R9 stray response while idle
    stray = 1;
    repeat (3) @(negedge clk);
    rd_chk(8'hD4, 32'h5A5A_0001, "R9 stray response ignored");
    // R6 other opcode
    wr(8'hD8, 32'hABCD_EF00);
    wr(8'hD0, 32'h7E10_2230);
    wait_idle();
    rd_chk(8'hD4, 32'h5A5A_0001, "R6 data unchanged");
    // back-to-back reads, zero-delay response
    rsp_val = 32'h0000_FFFF; rsp_dly = 0;
    wr(8'hD0, 32'h1000_00F0);
    rsp_val = 32'h8000_0001;
    wr(8'hD0, 32'h1001_0110);
    wait_idle();
    rd_chk(8'hD4, 32'h8000_0001, "R5 second read loaded");
    rd_chk(8'hD0, 32'h1001_0110, "R3 ctrl readback");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule